// File: doc/BRIEF.md
# Two-Bank Simultaneous Write/Read Memory

This block behaves like a simple dual-ported memory with one port that only writes and one port that only reads. Both ports can be used in every clock cycle. It is built from two single-ported banks, each as deep as the whole address space. A register array holds one bit per address, and that bit names the bank that holds the current value for the address.

A read uses the bank named by its address's bit. A write in the same cycle goes to the other bank, so neither bank ever sees two accesses in one cycle. The bit for the written address then changes to name the bank just written. A write with no read beside it goes to the bank that is not named by its own address's bit.

When the read address and the write address are equal, the read returns the value from before the write. The next read of that address returns the new value. Read data is registered and comes out one cycle after the request. Memory contents are undefined until written.

Top module: `pp_dual_mem`

## Requirements
- R1: In any cycle the block accepts one write and one read together, and both take effect in that cycle.
- R2: When `rdEn` is high in cycle n, `rdData` in cycle n+1 equals the last value written to `rdAddr` in a cycle before n.
- R3: When `wrEn` and `rdEn` are both high and `wrAddr` equals `rdAddr`, the read returns the value held before that cycle's write. A read of the same address in the next cycle returns the new value.
- R4: While `rstN` is low, and after reset until the first read completes, `rdData` is zero. Reset also sets every bank-select bit to bank 0.
- R5: `rdData` holds its value in every cycle that follows a cycle with `rdEn` low.
- R6: A write with no read in the same cycle is stored. When several writes hit one address in back-to-back cycles, the last one is the value kept.
- R7: No bank receives both a read and a write in the same cycle. During a same-address collision, the write goes to the bank the read is not using.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Registered read data, valid one cycle after the request |

## Verification
The hardest case to reach is a same-address collision where the select bit has already been flipped by earlier traffic, followed by a read of that address in the next cycle. Random addresses over the whole space seldom produce this. So the random stimulus forces the read address onto the write address in about a third of the cycles. Directed sequences also chain a collision, a re-read, and back-to-back writes to one address. Every cycle compares `rdData` against a reference model that returns the old data on a collision.

// File: rtl/pp_mem_pkg.sv
package pp_mem_pkg;

  // Strobes from the bank-steering control to the bank datapath
  typedef struct packed {
    logic wrStb;    // a write happens this cycle
    logic wrBank;   // bank receiving the write
    logic rdStb;    // a read happens this cycle
    logic rdBank;   // bank serving the read
    logic collide;  // read and write target the same address
  } pp_strobe_t;

endpackage

// File: rtl/pp_bank_ctrl.sv
module pp_bank_ctrl
  import pp_mem_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output pp_strobe_t        stb
);

  localparam int DEPTH = 1 << ADDR_W;

  // One bit per address: the bank holding its current value
  logic [DEPTH-1:0] selQ;
  logic             rdBank;
  logic             wrBank;

  always_comb begin
    rdBank = selQ[rdAddr];
    // With a read active, steer the write away from the read bank;
    // otherwise write the bank that does not hold the live value.
    wrBank = rdEn ? ~rdBank : ~selQ[wrAddr];
    stb.wrStb   = wrEn;
    stb.wrBank  = wrBank;
    stb.rdStb   = rdEn;
    stb.rdBank  = rdBank;
    stb.collide = wrEn && rdEn && (wrAddr == rdAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
    end else if (wrEn) begin
      selQ[wrAddr] <= wrBank;
    end
  end

  AST_SEL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> selQ[$past(wrAddr)] == $past(stb.wrBank)); // R6

  AST_COLLIDE_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.collide |-> (stb.wrBank != stb.rdBank)); // R7

endmodule

// File: rtl/pp_bank_datapath.sv
module pp_bank_datapath
  import pp_mem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pp_strobe_t        stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int BANKS = 2;

  logic [DATA_W-1:0] bankQ [BANKS];
  logic [BANKS-1:0]  bankWe;
  logic [BANKS-1:0]  bankRe;
  logic              rdBankQ;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];

    assign bankWe[b] = stb.wrStb && (stb.wrBank == b[0]);
    assign bankRe[b] = stb.rdStb && (stb.rdBank == b[0]);

    // Single-port array: one access per cycle
    always_ff @(posedge clk) begin
      if (bankWe[b]) begin
        mem[wrAddr] <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ[b] <= '0;
      end else if (bankRe[b]) begin
        bankQ[b] <= mem[rdAddr];
      end
    end

    AST_BANK_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
      !(bankWe[b] && bankRe[b])); // R7
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBankQ <= 1'b0;
    end else if (stb.rdStb) begin
      rdBankQ <= stb.rdBank;
    end
  end

  assign rdData = bankQ[rdBankQ];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb |-> $countones(bankWe) == 1); // R1

endmodule

// File: rtl/pp_dual_mem.sv
module pp_dual_mem
  import pp_mem_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  pp_strobe_t stb;

  pp_bank_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .stb    (stb)
  );

  pp_bank_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R5

endmodule

// File: tb/pp_dual_mem_tb.sv
module pp_dual_mem_tb_top;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] refMem [DEPTH];
  logic [DATA_W-1:0] expData = '0;
  string             expTag  = "R4";

  always #4 clk = ~clk;  // 125 MHz

  pp_dual_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic string classify(bit we, bit re, logic [ADDR_W-1:0] wa,
                                     logic [ADDR_W-1:0] ra);
    if (re && we && wa == ra) return "R3";
    if (re && we) return "R1";
    if (re) return "R2";
    return "R5";
  endfunction

  task automatic checkOut();
    checks++;
    if (rdData !== expData) begin
      fails++;
      $display("FAIL %s: rdData actual %h expected %h at %0t", expTag, rdData, expData, $time);
    end
  endtask

  // One cycle: check the output of the previous cycle, then drive new inputs
  task automatic step(bit we, logic [ADDR_W-1:0] wa, logic [DATA_W-1:0] wd,
                      bit re, logic [ADDR_W-1:0] ra);
    @(negedge clk);
    checkOut();
    wrEn = we; wrAddr = wa; wrData = wd;
    rdEn = re; rdAddr = ra;
    if (re) expData = refMem[ra];  // old data even on collision
    expTag = classify(we, re, wa, ra);
    if (we) refMem[wa] = wd;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) begin
      @(negedge clk);
      expTag = "R4";
      checkOut();  // R4: zero during reset
    end
    rstN = 1'b1;

    // R6: fill every address with writes only, twice back-to-back, last wins
    for (int a = 0; a < DEPTH; a++) begin
      expTag = "R4";
      step(1'b1, a[ADDR_W-1:0], 16'hDEAD, 1'b0, '0);
      step(1'b1, a[ADDR_W-1:0], DATA_W'(a * 16'h0101 + 3), 1'b0, '0);
    end
    step(1'b0, '0, '0, 1'b1, 6'd5);      // R6: read after write-only fill
    step(1'b0, '0, '0, 1'b0, '0);        // R5: hold

    // R3: collision, then re-read the same address
    step(1'b1, 6'd9, 16'hA5A5, 1'b1, 6'd9);
    step(1'b0, '0, '0, 1'b1, 6'd9);
    step(1'b1, 6'd9, 16'h5A5A, 1'b1, 6'd9);  // collision after the bit flipped
    step(1'b1, 6'd9, 16'h1111, 1'b1, 6'd9);
    step(1'b0, '0, '0, 1'b1, 6'd9);
    // R1: distinct addresses in the same cycle
    step(1'b1, 6'd10, 16'hBEEF, 1'b1, 6'd11);
    step(1'b1, 6'd11, 16'hCAFE, 1'b1, 6'd10);
    step(1'b0, '0, '0, 1'b1, 6'd11);

    // Random traffic with forced collisions
    for (int i = 0; i < 4000; i++) begin
      bit                we = ($urandom_range(99) < 70);
      bit                re = ($urandom_range(99) < 70);
      logic [ADDR_W-1:0] wa = ADDR_W'($urandom_range(DEPTH - 1));
      logic [ADDR_W-1:0] ra = ($urandom_range(99) < 35) ? wa
                              : ADDR_W'($urandom_range(DEPTH - 1));
      step(we, wa, DATA_W'($urandom), re, ra);
    end
    step(1'b0, '0, '0, 1'b0, '0);
    @(negedge clk);
    checkOut();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule